// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block controls the transfers of one channel of a multichannel SPI master. It holds the channel's configuration word, its enable bit and three status flags: transmit register empty, receive register full and end of transfer. It also holds the transmit and receive data words. A register-side strobe bus writes the configuration, writes the enable bit, loads a transmit word and signals a read of the received word. Each of the three trigger strobes starts a transfer attempt. In the cycle after the strobe, the sequencer checks the gating rules. It then starts the built-in MSB-first shifter, finishes the transfer at once without driving the line, or drops the attempt.

The gating depends on a two-bit transfer mode (transmit and receive, receive only, transmit only), on a turbo bit and on a force bit. The turbo bit lets transfers continue while the receive word is unread. The force bit drives the line even when the module-level single-channel input is set. Level outputs give the interrupt logic the conditions for transmit empty and receive full. Two request lines pace the DMA engine.

Top module: `spi_chan_seq`

## Requirements
- R1: After reset the configuration reads 0x060000, the status reads 3'b010 (bit 0 receive-full, bit 1 transmit-empty, bit 2 end-of-transfer), enable is 0, and the TX and RX words are 0.
- R2: A configuration write stores bits 22:0. Bits 13:12 are the mode (0 transmit and receive, 1 receive only, 2 transmit only). The word length is bits 11:7 plus one. Bit 14 enables the TX DMA request, bit 15 enables the RX DMA request, bit 19 is turbo and bit 20 is force.
- R3: Writing enable 1 while it is 0 sets it and starts an attempt. Any other enable write copies the written bit and starts nothing.
- R4: A TX write loads the word, clears transmit-empty and starts an attempt. An RX read strobe clears receive-full and starts an attempt. The attempt is evaluated in the next cycle.
- R5: An attempt is dropped when receive-full is set, the mode is not transmit-only and turbo is clear. It is also dropped when transmit-empty is set and the mode is not receive-only.
- R6: When the attempt passes and the single-channel input is clear or force is set, the shifter sends the low word-length bits of TX on mosi, MSB first, one bit per two clocks with sclk high in the second clock. It samples miso at the end of that clock. It completes 2×word-length cycles after the attempt, and RX then holds the received bits, zero-extended.
- R7: When the attempt passes with the single-channel input set and force clear, the transfer completes at the attempt cycle, with no sclk activity and RX unchanged.
- R8: On completion TX becomes 0 and end-of-transfer and transmit-empty are set. Receive-full is set too unless the mode is transmit-only. End-of-transfer stays set until reset.
- R9: The TX DMA request is enable AND config bit 14 AND transmit-empty AND the mode is not receive-only. The RX DMA request is enable AND config bit 15 AND receive-full AND the mode is not transmit-only.
- R10: The transmit-empty flag output is transmit-empty AND the mode is not receive-only. The receive-full flag output is receive-full AND the mode is not transmit-only AND turbo is clear.
- R11: The busy output is high while an attempt is pending or a shift runs. Every strobe in such a cycle is ignored.
- R12: With enable 0 an attempt starts no transfer and changes no flag, and both DMA requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| single_mode | input | 1 | Module single-channel setting; suppresses the line unless force is set |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 23 | Configuration write data |
| en_we | input | 1 | Enable write strobe |
| en_wdata | input | 1 | Enable write data |
| tx_we | input | 1 | TX word write strobe |
| tx_wdata | input | DW | TX word write data |
| rx_re | input | 1 | RX word read strobe |
| cfg_q | output | 23 | Configuration word |
| en_q | output | 1 | Enable bit |
| stat_q | output | 3 | Status: end-of-transfer, transmit-empty, receive-full |
| tx_q | output | DW | TX word |
| rx_q | output | DW | RX word |
| seq_busy | output | 1 | Attempt pending or shift running |
| txe_flag | output | 1 | Transmit-empty interrupt condition |
| rxf_flag | output | 1 | Receive-full interrupt condition |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A corrupted status flag shows up on stat_q, on the DMA request lines and on the interrupt condition outputs in the very next cycle. A wrong gating decision shows up one cycle after the trigger strobe, as busy and sclk activity that should not be there (or that is missing). Data faults in the shifter reach the ports at completion, through rx_q and through the bit stream seen on mosi, 2×word-length cycles after the attempt. A bench-side model that tracks every register cycle by cycle therefore catches each of these faults within one transfer.

// File: rtl/spi_chan_seq.sv
module spi_chan_seq #(
  parameter int DW = 32,
  parameter logic [22:0] CFG_RST = 23'h060000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          single_mode,
  input  logic          cfg_we,
  input  logic [22:0]   cfg_wdata,
  input  logic          en_we,
  input  logic          en_wdata,
  input  logic          tx_we,
  input  logic [DW-1:0] tx_wdata,
  input  logic          rx_re,
  output logic [22:0]   cfg_q,
  output logic          en_q,
  output logic [2:0]    stat_q,
  output logic [DW-1:0] tx_q,
  output logic [DW-1:0] rx_q,
  output logic          seq_busy,
  output logic          txe_flag,
  output logic          rxf_flag,
  output logic          dma_tx_req,
  output logic          dma_rx_req,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso
);
  localparam int LW = $clog2(DW) + 1;

  logic [22:0]   cfg;
  logic          en, txs, rxs, eot, pend, shifting, ph;
  logic [DW-1:0] txr, rxr, sh_tx, sh_rx;
  logic [LW-1:0] bitcnt;

  wire [1:0]    mode  = cfg[13:12];
  wire          turbo = cfg[19];
  wire          force_line = cfg[20];
  wire [LW-1:0] wl    = LW'(cfg[11:7]) + LW'(1);
  wire          not_rxo = (mode != 2'd1);
  wire          not_txo = (mode != 2'd2);
  wire          hold  = (rxs && not_txo && !turbo) || (txs && not_rxo);
  wire          line_ok = !single_mode || force_line;
  wire          last_bit = shifting && ph && (bitcnt == wl - LW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_RST; en <= 1'b0; txs <= 1'b1; rxs <= 1'b0; eot <= 1'b0;
      txr <= '0; rxr <= '0; pend <= 1'b0; shifting <= 1'b0; ph <= 1'b0;
      sh_tx <= '0; sh_rx <= '0; bitcnt <= '0;
    end else if (shifting) begin
      ph <= ~ph;
      if (ph) begin
        sh_tx  <= sh_tx << 1;
        sh_rx  <= {sh_rx[DW-2:0], miso};
        bitcnt <= bitcnt + LW'(1);
        if (last_bit) begin
          shifting <= 1'b0;
          rxr <= {sh_rx[DW-2:0], miso};
          txr <= '0; eot <= 1'b1; txs <= 1'b1;
          if (not_txo) rxs <= 1'b1;
        end
      end
    end else if (pend) begin
      pend <= 1'b0;
      if (en && !hold) begin
        if (line_ok) begin
          shifting <= 1'b1; ph <= 1'b0; bitcnt <= '0;
          sh_tx <= txr << (DW - int'(wl));
          sh_rx <= '0;
        end else begin
          txr <= '0; eot <= 1'b1; txs <= 1'b1;
          if (not_txo) rxs <= 1'b1;
        end
      end
    end else begin
      if (cfg_we) cfg <= cfg_wdata;
      if (en_we) begin
        if (en_wdata && !en) begin
          en <= 1'b1; pend <= 1'b1;
        end else begin
          en <= en_wdata;
        end
      end
      if (tx_we) begin
        txr <= tx_wdata; txs <= 1'b0; pend <= 1'b1;
      end
      if (rx_re) begin
        rxs <= 1'b0; pend <= 1'b1;
      end
    end
  end

  assign cfg_q      = cfg;
  assign en_q       = en;
  assign stat_q     = {eot, txs, rxs};
  assign tx_q       = txr;
  assign rx_q       = rxr;
  assign seq_busy   = pend | shifting;
  assign txe_flag   = txs && not_rxo;
  assign rxf_flag   = rxs && not_txo && !turbo;
  assign dma_tx_req = en && cfg[14] && txs && not_rxo;
  assign dma_rx_req = en && cfg[15] && rxs && not_txo;
  assign sclk       = shifting && ph;
  assign mosi       = shifting && sh_tx[DW-1];

  // R12
  disabled_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !shifting && !en) |=> (!shifting && $stable(stat_q)));

  // R5
  held_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !shifting && hold) |=> (!shifting && !pend));

  // R8
  done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(shifting) |-> (txs && eot && txr == '0));

  // R11
  busy_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |=> $stable(cfg_q));

  // R6
  shift_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shifting) |-> !sclk);
endmodule

// File: tb/sim_spi_chan_seq.sv
module sim_spi_chan_seq;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0, single_mode = 1'b0;
  logic cfg_we = 0, en_we = 0, en_wdata = 0, tx_we = 0, rx_re = 0, miso = 0;
  logic [22:0] cfg_wdata = '0;
  logic [DW-1:0] tx_wdata = '0;
  logic [22:0] cfg_q;
  logic en_q, seq_busy, txe_flag, rxf_flag, dma_tx_req, dma_rx_req, sclk, mosi;
  logic [2:0] stat_q;
  logic [DW-1:0] tx_q, rx_q;

  always #2 clk = ~clk;

  spi_chan_seq #(.DW(DW)) u0 (.*);

  int n_run = 0, n_fail = 0;
  bit armed = 0;
  string tag = "R1";

  task automatic chk(input string t, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, got, exp);
    end
  endtask

  // reference model
  logic [22:0] m_cfg; logic m_en, m_txs, m_rxs, m_eot, m_pend;
  logic [31:0] m_tx, m_rx, slv_word, exp_mosi;
  int m_rem = 0;

  function automatic int wlen(input logic [22:0] c); return int'(c[11:7]) + 1; endfunction
  function automatic logic [31:0] msk(input int w);
    logic [63:0] one = 64'd1;
    return 32'((one << w) - 64'd1);
  endfunction

  task automatic m_done();
    m_tx = 0; m_eot = 1; m_txs = 1;
    if (m_cfg[13:12] != 2) m_rxs = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 23'h060000; m_en = 0; m_txs = 1; m_rxs = 0; m_eot = 0;
      m_tx = 0; m_rx = 0; m_pend = 0; m_rem = 0;
    end else if (m_rem > 0) begin
      m_rem--;
      if (m_rem == 0) begin m_rx = slv_word & msk(wlen(m_cfg)); m_done(); end
    end else if (m_pend) begin
      logic [1:0] md;
      md = m_cfg[13:12];
      m_pend = 0;
      if (m_en && !((m_rxs && md != 2 && !m_cfg[19]) || (m_txs && md != 1))) begin
        if (!single_mode || m_cfg[20]) begin
          m_rem = 2 * wlen(m_cfg);
          exp_mosi = m_tx & msk(wlen(m_cfg));
        end else m_done();
      end
    end else begin
      if (cfg_we) m_cfg = cfg_wdata;
      if (en_we) begin
        if (en_wdata && !m_en) begin m_en = 1; m_pend = 1; end
        else m_en = en_wdata;
      end
      if (tx_we) begin m_tx = tx_wdata; m_txs = 0; m_pend = 1; end
      if (rx_re) begin m_rxs = 0; m_pend = 1; end
    end
  end

  // per-cycle compare, serial slave, mosi capture
  int scnt = 0, ccnt = 0;
  logic last_sclk = 0;
  logic [31:0] cap = 0;
  always @(negedge clk) begin
    if (armed) begin
      logic [1:0] md;
      md = m_cfg[13:12];
      chk("R2", "cfg", 64'(cfg_q), 64'(m_cfg));
      chk("R3", "enable", 64'(en_q), 64'(m_en));
      chk("R8", "status", 64'(stat_q), 64'({m_eot, m_txs, m_rxs}));
      chk("R4", "tx word", 64'(tx_q), 64'(m_tx));
      chk("R6", "rx word", 64'(rx_q), 64'(m_rx));
      chk("R11", "busy", 64'(seq_busy), 64'(m_pend || m_rem > 0));
      chk("R9", "dma tx", 64'(dma_tx_req), 64'(m_en && m_cfg[14] && m_txs && md != 1));
      chk("R9", "dma rx", 64'(dma_rx_req), 64'(m_en && m_cfg[15] && m_rxs && md != 2));
      chk("R10", "txe flag", 64'(txe_flag), 64'(m_txs && md != 1));
      chk("R10", "rxf flag", 64'(rxf_flag), 64'(m_rxs && md != 2 && !m_cfg[19]));
    end
    if (m_rem == 0) begin
      if (ccnt > 0) begin
        chk("R6", "mosi bits", 64'(ccnt), 64'(wlen(m_cfg)));
        chk("R6", "mosi word", 64'(cap), 64'(exp_mosi));
      end
      scnt = 0; ccnt = 0; cap = 0; last_sclk = 0;
    end else begin
      if (last_sclk) scnt++;
      last_sclk = sclk;
      if (sclk) begin cap = {cap[30:0], mosi}; ccnt++; end
    end
    if (m_rem == 0 && sclk) chk("R7", "sclk idle", 1, 0);
    miso = (scnt < wlen(m_cfg)) ? slv_word[wlen(m_cfg) - 1 - scnt] : 1'b0;
  end

  task automatic step(); @(negedge clk); endtask
  task automatic wr_cfg(input logic [22:0] v);
    step(); cfg_we = 1; cfg_wdata = v; step(); cfg_we = 0;
  endtask
  task automatic wr_en(input logic v);
    step(); en_we = 1; en_wdata = v; step(); en_we = 0;
  endtask
  task automatic wr_tx(input logic [31:0] v);
    step(); tx_we = 1; tx_wdata = v; step(); tx_we = 0;
  endtask
  task automatic rd_rx();
    step(); rx_re = 1; step(); rx_re = 0;
  endtask
  task automatic idle();
    for (int i = 0; i < 200 && seq_busy; i++) step();
    step();
  endtask

  initial begin
    slv_word = 0; exp_mosi = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1", "cfg", 64'(cfg_q), 64'h060000);
    chk("R1", "status", 64'(stat_q), 64'h2);
    chk("R1", "enable", 64'(en_q), 0);
    chk("R1", "rx", 64'(rx_q), 0);
    armed = 1;

    // R12: disabled channel, tx write clears TXS only
    wr_tx(32'h55); idle();
    chk("R12", "status", 64'(stat_q), 64'h0);
    chk("R12", "dma", 64'({dma_tx_req, dma_rx_req}), 0);

    // R2: wl 8, both DMA enables
    wr_cfg(23'h00C380); idle();
    chk("R2", "cfg", 64'(cfg_q), 64'h00C380);

    // R3 enable starts a transfer; R6 data
    slv_word = 32'h3C;
    wr_en(1); idle();
    chk("R6", "rx", 64'(rx_q), 64'h3C);
    chk("R8", "status", 64'(stat_q), 64'h7);
    chk("R9", "dma", 64'({dma_tx_req, dma_rx_req}), 64'h3);

    // R5 held by unread RX
    wr_tx(32'hA5); idle();
    chk("R5", "status", 64'(stat_q), 64'h5);
    chk("R10", "rxf", 64'(rxf_flag), 1);

    // R4 rx read releases it
    slv_word = 32'h81;
    rd_rx(); idle();
    chk("R4", "rx", 64'(rx_q), 64'h81);

    // R5 turbo lets transfer go with RX full
    wr_cfg(23'h08C380);
    slv_word = 32'hF0;
    wr_tx(32'h0F); idle();
    chk("R5", "turbo rx", 64'(rx_q), 64'hF0);
    chk("R10", "rxf turbo", 64'(rxf_flag), 0);

    // R8 transmit-only leaves RXS clear
    wr_cfg(23'h002380);
    rd_rx(); idle();
    slv_word = 32'h66;
    wr_tx(32'hC3); idle();
    chk("R8", "tx-only status", 64'(stat_q), 64'h6);

    // receive-only: TXS set does not hold
    wr_cfg(23'h001380);
    slv_word = 32'h9A;
    rd_rx(); idle();
    chk("R5", "rx-only rx", 64'(rx_q), 64'h9A);
    chk("R10", "txe rx-only", 64'(txe_flag), 0);

    // R7 single-channel without force
    wr_cfg(23'h000380);
    single_mode = 1;
    rd_rx(); idle();
    wr_tx(32'h12); idle();
    chk("R7", "rx kept", 64'(rx_q), 64'h9A);
    chk("R7", "status", 64'(stat_q), 64'h7);

    // R6 force overrides single-channel
    wr_cfg(23'h100380);
    slv_word = 32'h4E;
    rd_rx(); idle();
    wr_tx(32'hB7); idle();
    chk("R6", "force rx", 64'(rx_q), 64'h4E);
    single_mode = 0;

    // R6 32-bit word
    wr_cfg(23'h000F80);
    slv_word = 32'h12345678;
    rd_rx(); idle();
    wr_tx(32'hDEADBEEF); idle();
    chk("R6", "wl32 rx", 64'(rx_q), 64'h12345678);

    // R11 strobes while busy are ignored
    rd_rx(); idle();
    slv_word = 32'h0;
    step(); tx_we = 1; tx_wdata = 32'h1; step(); tx_we = 0;
    cfg_we = 1; cfg_wdata = 23'h0; rx_re = 1; en_we = 1; en_wdata = 0;
    step(); step();
    cfg_we = 0; rx_re = 0; en_we = 0;
    chk("R11", "cfg kept", 64'(cfg_q), 64'h000F80);
    chk("R11", "en kept", 64'(en_q), 1);
    idle();

    // R12 disable
    wr_en(0); idle();
    chk("R12", "dma off", 64'({dma_tx_req, dma_rx_req}), 0);
    rd_rx(); idle();
    wr_tx(32'h77); idle();
    chk("R12", "no transfer", 64'(stat_q), 64'h4);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule